// File: doc/BRIEF.md
# Lowest-Priority Interrupt Router

This block gathers external interrupt request lines and turns each one into a delivery message for a group of processors. Every line owns a programmable routing entry that holds a vector, a routing mode bit and a destination mask of CPUs. A request sets a sticky pending flag for its line. The router serves pending lines one at a time and places each on a message output made of a vector and a target CPU bitmask, which is guarded by a valid/ready handshake.

The routing mode picks how targets are chosen. In fixed mode the message carries the destination mask from the entry unchanged. That mask can name one CPU, several CPUs, or all of them. In balanced mode the router sends the interrupt to the single CPU whose task-priority input is lowest. When several CPUs share that lowest value, a per-CPU 4-bit rotation rank settles the tie. The rank of the CPU that receives the interrupt drops to zero and the ranks of the others move up, so interrupts spread in turn across equally loaded CPUs.

Top module: `lowpri_irq_router`

## Requirements
- R1: After reset `msgValid` is 0, every pending flag is clear, every routing entry is zero, and the rotation rank of CPU c equals c.
- R2: A write with `cfgWrEn` high stores the vector, the mode bit (1 = balanced, 0 = fixed) and the destination mask into the entry selected by `cfgWrIdx`. Every later message from that line uses the new contents.
- R3: A high bit on `reqLines` marks that line pending. When the output slot is free or is being accepted, the lowest-numbered pending line is issued and its flag is cleared, at one line per cycle. The order comes from the line number alone and never from the vector.
- R4: While `msgValid` is high and `msgReady` is low, `msgValid` stays high and `msgVector` and `msgTargets` hold their values.
- R5: A fixed-mode line produces `msgTargets` equal to the entry's destination mask and `msgVector` equal to the entry's vector. It leaves every rotation rank unchanged.
- R6: A balanced-mode line produces a one-hot `msgTargets` that selects a CPU whose `taskPri` field (CPU c at bits c*4 .. c*4+3) is the lowest of all CPUs.
- R7: Among CPUs tied at the lowest task priority, the CPU with the highest rotation rank is selected.
- R8: On each balanced-mode issue, the selected CPU's rank becomes 0 and every other CPU's rank increases by 1.
- R9: A non-selected CPU whose rank is 15 does not wrap to 0. It takes the selected CPU's previous rank plus 1.
- R10: A request sampled at one clock edge is not yet visible after that edge. With the slot free, the message appears after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Routing entry write strobe |
| cfgWrIdx | input | 5 | Line whose entry is written |
| cfgWrVector | input | 8 | Vector to store |
| cfgWrBalanced | input | 1 | Mode to store: 1 balanced, 0 fixed |
| cfgWrDest | input | 4 | Destination mask to store (fixed mode) |
| reqLines | input | 24 | Interrupt request lines, one bit per line |
| taskPri | input | 16 | Packed 4-bit task priority per CPU |
| msgReady | input | 1 | Consumer accepts the current message |
| msgValid | output | 1 | A message is present on the output |
| msgVector | output | 8 | Vector of the current message |
| msgTargets | output | 4 | Target CPU bitmask of the current message |

## Verification
Balanced-mode selection is tried in three kinds of cases. In the first, every CPU has the same task priority, so the rotation rank alone decides. In the second, one CPU has a strictly lowest priority, which shows the rank is ignored when the priorities differ. In the third, two CPUs tie while the others are higher, which shows that only the tied CPUs compete on rank. A long run that keeps selecting the same CPU drives another CPU's rank up to 15. The winners that follow show whether it took the winner's old rank plus one or wrapped to zero. Several lines are raised in the same cycle while the consumer stalls, which tests both the lowest-line-first order and how the output holds steady. A fixed-mode line placed between tie rounds shows that fixed traffic leaves the rotation untouched.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // width of a line index; bounds the number of request lines
  localparam int LINE_IDX_W = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic                  load;  // issue a message this cycle
    logic [LINE_IDX_W-1:0] line;  // line being issued
  } route_strobe_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] reqLines,
  input  logic                 msgReady,
  output logic                 msgValid,
  output route_strobe_t        strobe
);
  logic [NUM_LINES-1:0]  pending;
  logic [NUM_LINES-1:0]  clearMask;
  logic                  anyPend;
  logic                  issue;
  logic [LINE_IDX_W-1:0] pickIdx;

  // lowest-numbered pending line wins
  always_comb begin
    anyPend = 1'b0;
    pickIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pending[i]) begin
        anyPend = 1'b1;
        pickIdx = LINE_IDX_W'(i);
      end
    end
  end

  assign issue     = anyPend && (!msgValid || msgReady);
  assign clearMask = issue ? (NUM_LINES'(1) << pickIdx) : '0;
  assign strobe    = '{load: issue, line: pickIdx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= '0;
      msgValid <= 1'b0;
    end else begin
      // a fresh request in the issuing cycle re-arms its line
      pending  <= (pending & ~clearMask) | reqLines;
      msgValid <= issue | (msgValid & ~msgReady);
    end
  end

  // R4: a stalled message is not withdrawn
  a_r4_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    msgValid && !msgReady |=> msgValid);

  // R3: an issued line leaves the pending set unless re-requested
  a_r3_served_clears: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load && !reqLines[strobe.line] |=> !pending[$past(strobe.line)]);

  // R3: requests are captured
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|reqLines) |=> (|pending));
endmodule

// File: rtl/irq_router_dpath.sv
module irq_router_dpath
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int NUM_CPUS  = 4,
  parameter int VEC_W     = 8,
  parameter int TPR_W     = 4,
  parameter int ARB_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfgWrEn,
  input  logic [LINE_IDX_W-1:0]     cfgWrIdx,
  input  logic [VEC_W-1:0]          cfgWrVector,
  input  logic                      cfgWrBalanced,
  input  logic [NUM_CPUS-1:0]       cfgWrDest,
  input  logic [NUM_CPUS*TPR_W-1:0] taskPri,
  input  route_strobe_t             strobe,
  output logic [VEC_W-1:0]          msgVector,
  output logic [NUM_CPUS-1:0]       msgTargets
);
  localparam int CPU_IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam logic [ARB_W-1:0] ARB_MAX = '1;

  logic [VEC_W-1:0]    entVec  [NUM_LINES];
  logic                entBal  [NUM_LINES];
  logic [NUM_CPUS-1:0] entDest [NUM_LINES];
  logic [ARB_W-1:0]    arb     [NUM_CPUS];
  logic [TPR_W-1:0]    tpOf    [NUM_CPUS];

  logic [VEC_W-1:0]     selVec;
  logic                 selBal;
  logic [NUM_CPUS-1:0]  selDest;
  logic [TPR_W-1:0]     minTp;
  logic [CPU_IDX_W-1:0] winIdx;
  logic [ARB_W-1:0]     winArb;
  logic                 found;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_tp
    assign tpOf[c] = taskPri[c*TPR_W +: TPR_W];
  end

  assign selVec  = entVec[strobe.line];
  assign selBal  = entBal[strobe.line];
  assign selDest = entDest[strobe.line];

  // lowest task priority, then highest rank, then lowest index
  always_comb begin
    minTp = '1;
    for (int c = 0; c < NUM_CPUS; c++)
      if (tpOf[c] < minTp) minTp = tpOf[c];
    found  = 1'b0;
    winIdx = '0;
    winArb = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (tpOf[c] == minTp && (!found || arb[c] > winArb)) begin
        found  = 1'b1;
        winIdx = CPU_IDX_W'(c);
        winArb = arb[c];
      end
    end
  end

  // routing entry table
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        entVec[i]  <= '0;
        entBal[i]  <= 1'b0;
        entDest[i] <= '0;
      end
    end else if (cfgWrEn && int'(cfgWrIdx) < NUM_LINES) begin
      entVec[cfgWrIdx]  <= cfgWrVector;
      entBal[cfgWrIdx]  <= cfgWrBalanced;
      entDest[cfgWrIdx] <= cfgWrDest;
    end
  end

  // rotation ranks
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPUS; c++) arb[c] <= ARB_W'(c);
    end else if (strobe.load && selBal) begin
      for (int c = 0; c < NUM_CPUS; c++) begin
        if (CPU_IDX_W'(c) == winIdx) arb[c] <= '0;
        else if (arb[c] == ARB_MAX)  arb[c] <= ARB_W'(winArb + 1'b1);
        else                         arb[c] <= ARB_W'(arb[c] + 1'b1);
      end
    end
  end

  // message register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msgVector  <= '0;
      msgTargets <= '0;
    end else if (strobe.load) begin
      msgVector  <= selVec;
      msgTargets <= selBal ? (NUM_CPUS'(1) << winIdx) : selDest;
    end
  end

  // R4: payload only moves on an issue
  a_r4_stable_payload: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> $stable(msgVector) && $stable(msgTargets));

  // R6: balanced delivery names exactly one CPU
  a_r6_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load && selBal |=> $countones(msgTargets) == 1);

  // R8: the selected CPU restarts at rank zero
  a_r8_winner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load && selBal |=> arb[$past(winIdx)] == '0);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_chk
    // R5: fixed delivery leaves ranks alone
    a_r5_static_keeps_rank: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.load && !selBal |=> $stable(arb[c]));
  end
endmodule

// File: rtl/lowpri_irq_router.sv
module lowpri_irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int NUM_CPUS  = 4,
  parameter int VEC_W     = 8,
  parameter int TPR_W     = 4,
  parameter int ARB_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfgWrEn,
  input  logic [LINE_IDX_W-1:0]     cfgWrIdx,
  input  logic [VEC_W-1:0]          cfgWrVector,
  input  logic                      cfgWrBalanced,
  input  logic [NUM_CPUS-1:0]       cfgWrDest,
  input  logic [NUM_LINES-1:0]      reqLines,
  input  logic [NUM_CPUS*TPR_W-1:0] taskPri,
  input  logic                      msgReady,
  output logic                      msgValid,
  output logic [VEC_W-1:0]          msgVector,
  output logic [NUM_CPUS-1:0]       msgTargets
);
  route_strobe_t strobe;

  irq_router_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqLines (reqLines),
    .msgReady (msgReady),
    .msgValid (msgValid),
    .strobe   (strobe)
  );

  irq_router_dpath #(
    .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .VEC_W(VEC_W),
    .TPR_W(TPR_W), .ARB_W(ARB_W)
  ) u_dpath (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfgWrEn       (cfgWrEn),
    .cfgWrIdx      (cfgWrIdx),
    .cfgWrVector   (cfgWrVector),
    .cfgWrBalanced (cfgWrBalanced),
    .cfgWrDest     (cfgWrDest),
    .taskPri       (taskPri),
    .strobe        (strobe),
    .msgVector     (msgVector),
    .msgTargets    (msgTargets)
  );
endmodule

// File: tb/lowpri_irq_router_tb.sv
`timescale 1ns/1ps
module lowpri_irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [4:0]  cfgWrIdx = '0;
  logic [7:0]  cfgWrVector = '0;
  logic        cfgWrBalanced = 1'b0;
  logic [3:0]  cfgWrDest = '0;
  logic [23:0] reqLines = '0;
  logic [15:0] taskPri = '0;
  logic        msgReady = 1'b1;
  logic        msgValid;
  logic [7:0]  msgVector;
  logic [3:0]  msgTargets;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lowpri_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .cfgWrVector(cfgWrVector), .cfgWrBalanced(cfgWrBalanced), .cfgWrDest(cfgWrDest),
    .reqLines(reqLines), .taskPri(taskPri), .msgReady(msgReady),
    .msgValid(msgValid), .msgVector(msgVector), .msgTargets(msgTargets)
  );

  typedef struct packed {
    logic [4:0]  line;
    logic [15:0] tp;
    logic [7:0]  vec;
    logic [3:0]  tgt;
  } case_t;

  // rows walked in order; expected targets follow the rotation from reset
  localparam case_t CASES [7] = '{
    '{line: 5'd3, tp: 16'h5555, vec: 8'h43, tgt: 4'b1000},  // R1 R7 all tied
    '{line: 5'd3, tp: 16'h5555, vec: 8'h43, tgt: 4'b0100},  // R8 rotation
    '{line: 5'd5, tp: 16'h0000, vec: 8'h55, tgt: 4'b1010},  // R5 fixed subset
    '{line: 5'd7, tp: 16'h9992, vec: 8'h77, tgt: 4'b0001},  // R6 unique min
    '{line: 5'd3, tp: 16'h7771, vec: 8'h43, tgt: 4'b0001},  // R6 unique min
    '{line: 5'd3, tp: 16'h9779, vec: 8'h43, tgt: 4'b0010},  // R7 partial tie
    '{line: 5'd7, tp: 16'h3330, vec: 8'h77, tgt: 4'b0001}   // R6
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic write_entry(input int idx, input logic [7:0] v, input logic bal,
                             input logic [3:0] dest);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrIdx = 5'(idx); cfgWrVector = v;
    cfgWrBalanced = bal; cfgWrDest = dest;
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // pulse one line, check latency, then check the single message
  task automatic deliver(input int line, input logic [15:0] tp, input logic [7:0] ev,
                         input logic [3:0] et, input string tag);
    @(negedge clk);
    taskPri = tp;
    reqLines = 24'(1) << line;
    @(posedge clk);
    @(negedge clk);
    reqLines = '0;
    check(msgValid == 1'b0, "R10 not visible after capture edge", 32'(msgValid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check(msgValid && msgVector == ev && msgTargets == et, tag,
          {19'd0, msgValid, msgVector, msgTargets}, {19'd0, 1'b1, ev, et});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(msgValid == 1'b0, "R1 valid low in reset", 32'(msgValid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(msgValid == 1'b0 && msgTargets == 4'd0, "R1 idle after reset",
          {27'd0, msgValid, msgTargets}, 32'd0);

    // R2 program entries
    write_entry(3, 8'h43, 1'b1, 4'b0000);
    write_entry(5, 8'h55, 1'b0, 4'b1010);
    write_entry(7, 8'h77, 1'b1, 4'b0000);

    for (int i = 0; i < 7; i++)
      deliver(int'(CASES[i].line), CASES[i].tp, CASES[i].vec, CASES[i].tgt,
              $sformatf("R6/R7/R8 table row %0d", i));

    // R9: keep CPU0 winning until CPU3 saturates, then one more
    for (int i = 0; i < 11; i++)
      deliver(3, 16'hFFF0, 8'h43, 4'b0001, "R8 repeated unique winner");
    deliver(3, 16'h4444, 8'h43, 4'b0100, "R9 rank-15 CPU wins tie");
    deliver(5, 16'h4444, 8'h55, 4'b1010, "R5 fixed line between ties");
    deliver(3, 16'h4444, 8'h43, 4'b0010, "R5 rotation untouched by fixed");
    deliver(3, 16'h4444, 8'h43, 4'b1000, "R9 saturated rank took winner+1");

    // R2 rewrite a line; R5 broadcast on the top line
    write_entry(5, 8'h5A, 1'b0, 4'b0001);
    deliver(5, 16'h0000, 8'h5A, 4'b0001, "R2 rewritten entry");
    write_entry(23, 8'hE7, 1'b0, 4'b1111);
    deliver(23, 16'h0000, 8'hE7, 4'b1111, "R5 broadcast on last line");

    // R3/R4 ordering under back-pressure
    write_entry(2, 8'h22, 1'b0, 4'b0011);
    write_entry(4, 8'h44, 1'b0, 4'b0100);
    write_entry(9, 8'h99, 1'b0, 4'b1111);
    @(negedge clk);
    msgReady = 1'b0;
    reqLines = (24'(1) << 9) | (24'(1) << 4) | (24'(1) << 2);
    @(posedge clk);
    @(negedge clk);
    reqLines = '0;
    @(posedge clk);
    @(negedge clk);
    check(msgValid && msgVector == 8'h22, "R3 lowest line first",
          {23'd0, msgValid, msgVector}, {23'd0, 1'b1, 8'h22});
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(msgValid && msgVector == 8'h22 && msgTargets == 4'b0011, "R4 held while stalled",
          {19'd0, msgValid, msgVector, msgTargets}, {19'd0, 1'b1, 8'h22, 4'b0011});
    msgReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(msgValid && msgVector == 8'h44, "R3 second line next cycle",
          {23'd0, msgValid, msgVector}, {23'd0, 1'b1, 8'h44});
    @(posedge clk);
    @(negedge clk);
    check(msgValid && msgVector == 8'h99 && msgTargets == 4'b1111, "R3 third line",
          {19'd0, msgValid, msgVector, msgTargets}, {19'd0, 1'b1, 8'h99, 4'b1111});
    @(posedge clk);
    @(negedge clk);
    check(msgValid == 1'b0, "R3 queue drained", 32'(msgValid), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule